// File: doc/BRIEF.md
# Presettable cascadable binary counter

A synchronous binary up-counter, four bits wide by default, that can be preset from a data word, held, or stepped. It has two active-high count enables: the counter steps only when both are high. Only one of them, the carry-in enable, also gates the terminal-count output. Because of this, many stages can be chained into one wide counter. Each stage's terminal count drives the next stage's carry-in enable, and the other enable serves as a common run/stop control.

The clear input is active low. A compile-time parameter selects how it behaves. In immediate mode, a low clear forces the count to zero at once, with no clock edge needed. In clocked mode, the clear is sampled like any other control at the rising edge and wins over every other operation. Clocked mode lets a decode of the count drive the clear, which shortens the counting modulus.

Top module: `preset_counter`

## Requirements
- R1: The count changes only at a rising clock edge. Changing the data word, load or enables between edges leaves the count unchanged (except for an immediate clear, R6).
- R2: When load_n is 0 at a rising edge (and no clock-sampled clear is active), the count takes the value of din, whatever en_run and en_carry are.
- R3: When load_n is 1 and both en_run and en_carry are 1 at a rising edge, the count increases by one.
- R4: When load_n is 1 and either en_run or en_carry is 0 at a rising edge, the count keeps its value.
- R5: tc is 1 exactly when en_carry is 1 and the count is all ones (15 for four bits). It is combinational in en_carry, so a change on en_carry reaches tc without a clock edge. en_run has no effect on tc.
- R6: With ASYNC_CLEAR=1, clr_n at 0 forces the count to 0 without a clock edge, regardless of load_n, en_run and en_carry.
- R7: With ASYNC_CLEAR=0, clr_n at 0 has no effect before the next rising edge. At that edge the count becomes 0, overriding both load and count.
- R8: Counting from all ones wraps to 0.
- R9: Chained stages, with each stage's tc driving the next stage's en_carry and all other enables high, advance together as one wide binary counter.
- R10: In clocked-clear mode, driving clr_n low when the count equals a chosen value K makes the counter cycle 0..K, a modulus of K+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; immediate or clock-sampled per ASYNC_CLEAR |
| load_n | input | 1 | Active-low parallel preset |
| en_run | input | 1 | Count enable that does not gate tc |
| en_carry | input | 1 | Count enable that also gates tc |
| din | input | WIDTH | Preset data word |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: en_carry and count all ones |

## Verification
The bench targets these corner cases:
- **Load against both enables low.** A design with the priorities swapped would hold instead of loading.
- **Wrap from 15 to 0.** A counter that saturated or carried into a wider register would stick at 15 or show a wrong value.
- **Clear timing.** The clear arrives mid-cycle and is checked before and after the edge. An immediate clear that waited for the clock, or a clocked clear that acted early or lost to load, shows a wrong count.
- **tc gating.** tc is checked with en_run low and then en_carry low, to catch a tc gated by the wrong enable or latched from the clock.
- **Chained and decoded use.** A three-stage chain is followed past the 255-to-256 boundary, and a decoded clear shortens the modulus to seven. Both expose off-by-one carry or clear timing.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;

  // Priority at an edge: clocked clear, then preset, then step, then hold.
  function automatic ctr_op_e pick_op(input logic sync_clr,
                                      input logic load_n,
                                      input logic en_a,
                                      input logic en_b);
    if (sync_clr)          return OP_CLEAR;
    else if (!load_n)      return OP_LOAD;
    else if (en_a && en_b) return OP_STEP;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/ctr_mode_sel.sv
module ctr_mode_sel
  import ctr_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_run,
  input  logic    en_carry,
  output ctr_op_e op,
  output logic    want_step
);

  logic sync_clr;

  generate
    if (ASYNC_CLEAR) begin : g_imm
      assign sync_clr = 1'b0;
    end else begin : g_clk
      assign sync_clr = ~clr_n;
    end
  endgenerate

  always_comb op = pick_op(sync_clr, load_n, en_run, en_carry);

  assign want_step = (op == OP_STEP);

endmodule

// File: rtl/ctr_state.sv
module ctr_state
  import ctr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = '0;

  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = bump(q);
      default:  nxt = q;
    endcase
  end

  generate
    if (ASYNC_CLEAR) begin : g_imm
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= ZERO;
        else        q <= nxt;
      end
    end else begin : g_clk
      always_ff @(posedge clk) q <= nxt;
    end
  endgenerate

endmodule

// File: rtl/ctr_term.sv
module ctr_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_carry,
  output logic             at_top,
  output logic             tc
);

  assign at_top = &q;
  assign tc     = en_carry & at_top;

endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_run,
  input  logic             en_carry,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  ctr_op_e op;
  logic    want_step;
  logic    at_top;

  ctr_mode_sel #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_sel (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .en_run   (en_run),
    .en_carry (en_carry),
    .op       (op),
    .want_step(want_step)
  );

  ctr_state #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_state (
    .clk  (clk),
    .clr_n(clr_n),
    .op   (op),
    .din  (din),
    .q    (q)
  );

  ctr_term #(.WIDTH(WIDTH)) u_term (
    .q       (q),
    .en_carry(en_carry),
    .at_top  (at_top),
    .tc      (tc)
  );

  // Checker qualifier: the count is known once a clear has been seen at an edge.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  p_load_r2: assert property (@(posedge clk) disable iff (!primed || !clr_n)
    !load_n |=> q == $past(din));

  p_step_r3: assert property (@(posedge clk) disable iff (!primed || !clr_n)
    want_step && !at_top |=> q == $past(q) + ONE_W);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!primed || !clr_n)
    want_step && at_top |=> q == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!primed || !clr_n)
    load_n && !(en_run && en_carry) |=> $stable(q));

  p_tc_gate_r5: assert property (@(posedge clk) disable iff (!primed)
    tc |-> (en_carry && q == ALL_ONES));

  localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

  generate
    if (ASYNC_CLEAR) begin : g_chk_imm
      p_clear_now_r6: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |-> q == '0);
    end else begin : g_chk_clk
      p_clear_edge_r7: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |=> q == '0);
    end
  endgenerate

endmodule

// File: tb/sim_preset_counter.sv
module sim_preset_counter;

  localparam int CLK_P = 10;
  localparam int NST   = 3;
  localparam logic [3:0] MOD_TOP = 4'd6;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic       clr_n = 1'b0, load_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q0, q1;
  logic       tc0, tc1;

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_run(ep), .en_carry(et),
    .din(din), .q(q0), .tc(tc0));

  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_run(ep), .en_carry(et),
    .din(din), .q(q1), .tc(tc1));

  // Cascade of clocked-clear stages (R9)
  logic       c_clr_n = 1'b0;
  logic [3:0] cq  [NST];
  logic       ctc [NST];
  generate
    for (genvar k = 0; k < NST; k++) begin : g_chain
      logic cin;
      if (k == 0) begin : g_first
        assign cin = 1'b1;
      end else begin : g_next
        assign cin = ctc[k-1];
      end
      preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_c (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_run(1'b1),
        .en_carry(cin), .din(4'd0), .q(cq[k]), .tc(ctc[k]));
    end
  endgenerate

  // Shortened modulus by decoded clear (R10)
  logic       m_rst_n = 1'b0;
  logic [3:0] mq;
  logic       mtc;
  logic       m_clr_n;
  assign m_clr_n = m_rst_n & (mq != MOD_TOP);
  preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_m (
    .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_run(1'b1), .en_carry(1'b1),
    .din(4'd0), .q(mq), .tc(mtc));

  function automatic logic [3:0] ref_next(logic [3:0] cur, logic c, logic l,
                                          logic p, logic t, logic [3:0] d);
    if (!c)          return 4'd0;
    if (!l)          return d;
    if (p && t)      return 4'((int'(cur) + 1) % 16);
    return cur;
  endfunction

  function automatic logic ref_tc(logic [3:0] cur, logic t);
    return t && (cur == 4'd15);
  endfunction

  function automatic string tag_of(logic [3:0] cur, logic c, logic l,
                                   logic p, logic t, bit imm);
    if (!c)     return imm ? "R6" : "R7";
    if (!l)     return "R2";
    if (p && t) return (cur == 4'd15) ? "R8" : "R3";
    return "R4";
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [3:0] e0 = 4'd0, e1 = 4'd0;

  task automatic cyc(logic c, logic l, logic p, logic t, logic [3:0] d);
    logic [3:0] n0, n1;
    string s0, s1;
    @(negedge clk);
    clr_n = c; load_n = l; ep = p; et = t; din = d;
    #1;
    if (!c) begin
      chk("R6", q0, 0);
      e0 = 4'd0;
    end else chk("R1", q0, e0);
    chk(c ? "R1" : "R7", q1, e1);
    chk("R5", tc0, ref_tc(e0, t));
    chk("R5", tc1, ref_tc(e1, t));
    s0 = tag_of(e0, c, l, p, t, 1'b1);
    s1 = tag_of(e1, c, l, p, t, 1'b0);
    n0 = ref_next(e0, c, l, p, t, d);
    n1 = ref_next(e1, c, l, p, t, d);
    @(posedge clk);
    #1;
    e0 = n0; e1 = n1;
    chk(s0, q0, e0);
    chk(s1, q1, e1);
    chk("R5", tc0, ref_tc(e0, t));
    chk("R5", tc1, ref_tc(e1, t));
  endtask

  bit finished = 1'b0;
  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset state
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'd9);
    // R2: load with both enables low, then with both high
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd13);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'd14);
    // R3 then R8 wrap 14->15->0->1
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd3);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd3);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'd3);
    // R5: reach 15 and toggle enables; R4 hold each way
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'd15);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'd2);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'd2);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'd2);
    // R7: clear against load and count
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'd11);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'd7);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'd7);
    // random mix
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 16) != 0, ($urandom % 6) != 0, ($urandom % 4) != 0,
          ($urandom % 4) != 0, 4'($urandom % 16));
    end

    // R9: three-stage chain through the 255/256 boundary
    @(negedge clk); c_clr_n = 1'b0;
    @(negedge clk); c_clr_n = 1'b1;
    for (int n = 0; n < 300; n++) begin
      #1;
      chk("R9", {cq[2], cq[1], cq[0]}, n);
      @(negedge clk);
    end

    // R10: decoded clear at 6 gives modulus 7
    m_rst_n = 1'b0;
    @(negedge clk); m_rst_n = 1'b1;
    for (int n = 0; n < 30; n++) begin
      #1;
      chk("R10", mq, n % (int'(MOD_TOP) + 1));
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule